// File: doc/BRIEF.md
# Free-Running Time Base with Compare Interrupt

This peripheral keeps a 56-bit time base that never stops while the chip is powered. It advances by one on every clock edge where the tick qualifier is high. Software reads the time base as two 32-bit words over a small register bus. A single compare unit watches the time base against a 64-bit threshold. Once the time base has reached the threshold, the compare unit raises a level interrupt.

Software arms the compare unit by loading the two threshold words and then setting the enable bit. It acknowledges the interrupt only by clearing the enable bit. Clearing enable also drops the latched status. A mask bit holds the interrupt pin low without stopping the status from updating. The register bus accepts one access per cycle and never stalls. A read returns its data one cycle after it is accepted.

Top module: `time_base_cmp`

## Requirements
- R1: Reset clears the time base, both threshold words and all control bits, and holds `irq` low.
- R2: The time base increments by one on each rising edge where `tickEn` is 1 and holds otherwise. Byte offset 0x8 reads time base bits 31:0. Offset 0xC reads bits 55:32 in data bits 23:0, with data bits 31:24 zero.
- R3: The threshold low word at byte offset 0x10020 and the high word at 0x10024 are writable and read back the full 32 bits written.
- R4: The control word at byte offset 0x1002C holds enable in bit 0 and mask in bit 1, both read/write. Bit 2 returns the status and ignores writes. All other bits read zero.
- R5: While enabled, status sets on the rising edge at which the threshold, as held before that edge, is less than or equal to the zero-extended time base as held before that edge. Equality counts as a match.
- R6: A threshold with any bit set above bit 55 never matches.
- R7: Once set, status stays set while enable stays 1, even if the threshold is rewritten to a larger value.
- R8: A control write with bit 0 equal to 0 clears status at that same edge, and `irq` is low after it. This is the only way to clear status.
- R9: `irq` equals status while mask is 0 and is held low while mask is 1. Status keeps updating while masked.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: `busReady` is always 1. A read accepted at an edge gives `rspValid` 1 and its data on `rspData` during the following cycle.
- R12: A control write that sets enable while the threshold is already at or below the time base sets status at the edge of that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | Advance the time base on this edge |
| busValid | input | 1 | Bus request present |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | ADDR_W (17) | Byte address of the access |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Request accepted (always 1) |
| rspValid | output | 1 | Read data valid |
| rspData | output | 32 | Read data |
| irq | output | 1 | Active-high level compare interrupt |

## Verification
The hardest case to reach from the ports is the exact edge where the time base first equals the threshold. It has to be told apart from the edge before and the edge after. The bench holds `tickEn` low to freeze the time base at a known value while it arms the compare unit. It then releases exactly five ticks and samples `irq` at the edge where the match takes effect and at the edge before it. The same freeze lets one table of threshold and control vectors cover the below, equal, above and out-of-range cases against a single fixed time base.

// File: rtl/tbc_pkg.sv
package tbc_pkg;
  localparam int DATA_W = 32;
  localparam int CMP_W  = 2 * DATA_W;

  // byte offsets of the mapped words
  localparam logic [31:0] OFS_CNT_LO   = 32'h0000_0008;
  localparam logic [31:0] OFS_CNT_HI   = 32'h0000_000C;
  localparam logic [31:0] OFS_CMP_BASE = 32'h0001_0000;
  localparam logic [31:0] OFS_CMP_LO   = OFS_CMP_BASE + 32'h20;
  localparam logic [31:0] OFS_CMP_HI   = OFS_CMP_BASE + 32'h24;
  localparam logic [31:0] OFS_CTRL     = OFS_CMP_BASE + 32'h2C;

  // control word bit positions
  localparam int BIT_EN   = 0;
  localparam int BIT_MASK = 1;
  localparam int BIT_STAT = 2;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CNT_LO,
    SEL_CNT_HI,
    SEL_CMP_LO,
    SEL_CMP_HI,
    SEL_CTRL
  } regSelT;

  // strobes from register decode into the datapath
  typedef struct packed {
    logic wrCmpLo;
    logic wrCmpHi;
    logic wrCtrl;
  } regStrobeT;
endpackage

// File: rtl/tbc_regif.sv
module tbc_regif
  import tbc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 56
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [ADDR_W-1:0]   busAddr,
  output logic                busReady,
  output logic                rspValid,
  output logic [DATA_W-1:0]   rspData,
  input  logic [CNT_W-1:0]    cntVal,
  input  logic [CMP_W-1:0]    cmpVal,
  input  logic                enQ,
  input  logic                maskQ,
  input  logic                statusQ,
  output regStrobeT           strb
);
  localparam int PAD_W = CMP_W - CNT_W;

  logic [31:0]       addrFull;
  regSelT            sel;
  logic              wrAcc;
  logic              rdAcc;
  logic [CMP_W-1:0]  cntWide;
  logic [DATA_W-1:0] rdMux;

  assign addrFull = {{(32 - ADDR_W){1'b0}}, busAddr};
  assign cntWide  = {{PAD_W{1'b0}}, cntVal};
  assign busReady = 1'b1;
  assign wrAcc    = busValid && busWrite;
  assign rdAcc    = busValid && !busWrite;

  always_comb begin
    case (addrFull)
      OFS_CNT_LO: sel = SEL_CNT_LO;
      OFS_CNT_HI: sel = SEL_CNT_HI;
      OFS_CMP_LO: sel = SEL_CMP_LO;
      OFS_CMP_HI: sel = SEL_CMP_HI;
      OFS_CTRL:   sel = SEL_CTRL;
      default:    sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strb         = '0;
    strb.wrCmpLo = wrAcc && (sel == SEL_CMP_LO);
    strb.wrCmpHi = wrAcc && (sel == SEL_CMP_HI);
    strb.wrCtrl  = wrAcc && (sel == SEL_CTRL);
  end

  always_comb begin
    rdMux = '0;
    case (sel)
      SEL_CNT_LO: rdMux = cntWide[DATA_W-1:0];
      SEL_CNT_HI: rdMux = cntWide[CMP_W-1:DATA_W];
      SEL_CMP_LO: rdMux = cmpVal[DATA_W-1:0];
      SEL_CMP_HI: rdMux = cmpVal[CMP_W-1:DATA_W];
      SEL_CTRL: begin
        rdMux[BIT_EN]   = enQ;
        rdMux[BIT_MASK] = maskQ;
        rdMux[BIT_STAT] = statusQ;
      end
      default:    rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= rdAcc;
      if (rdAcc) rspData <= rdMux;
    end
  end
endmodule

// File: rtl/tbc_datapath.sv
module tbc_datapath
  import tbc_pkg::*;
#(
  parameter int CNT_W = 56
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickEn,
  input  regStrobeT          strb,
  input  logic [DATA_W-1:0]  wdata,
  output logic [CNT_W-1:0]   cntVal,
  output logic [CMP_W-1:0]   cmpVal,
  output logic               enQ,
  output logic               maskQ,
  output logic               statusQ,
  output logic               irq
);
  localparam int PAD_W   = CMP_W - CNT_W;
  localparam int N_WORDS = CMP_W / DATA_W;

  logic [N_WORDS-1:0] wordWr;
  logic               enNext;
  logic               hit;

  assign wordWr = {strb.wrCmpHi, strb.wrCmpLo};

  // free-running time base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       cntVal <= '0;
    else if (tickEn) cntVal <= cntVal + CNT_W'(1);
  end

  // threshold words, one register per bus word
  for (genvar k = 0; k < N_WORDS; k++) begin : gCmpWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          cmpVal[k*DATA_W +: DATA_W] <= '0;
      else if (wordWr[k]) cmpVal[k*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      maskQ <= 1'b0;
    end else if (strb.wrCtrl) begin
      enQ   <= wdata[BIT_EN];
      maskQ <= wdata[BIT_MASK];
    end
  end

  assign enNext = strb.wrCtrl ? wdata[BIT_EN] : enQ;
  assign hit    = (cmpVal <= {{PAD_W{1'b0}}, cntVal});

  // status latches on a match and is only released by disabling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) statusQ <= 1'b0;
    else       statusQ <= enNext && (statusQ || hit);
  end

  assign irq = statusQ && !maskQ;
endmodule

// File: rtl/time_base_cmp.sv
module time_base_cmp
  import tbc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 56
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic              busReady,
  output logic              rspValid,
  output logic [31:0]       rspData,
  output logic              irq
);
  regStrobeT         strb;
  logic [CNT_W-1:0]  cntVal;
  logic [CMP_W-1:0]  cmpVal;
  logic              enQ;
  logic              maskQ;
  logic              statusQ;

  tbc_regif #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regif (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busAddr  (busAddr),
    .busReady (busReady),
    .rspValid (rspValid),
    .rspData  (rspData),
    .cntVal   (cntVal),
    .cmpVal   (cmpVal),
    .enQ      (enQ),
    .maskQ    (maskQ),
    .statusQ  (statusQ),
    .strb     (strb)
  );

  tbc_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .tickEn  (tickEn),
    .strb    (strb),
    .wdata   (busWdata),
    .cntVal  (cntVal),
    .cmpVal  (cmpVal),
    .enQ     (enQ),
    .maskQ   (maskQ),
    .statusQ (statusQ),
    .irq     (irq)
  );
endmodule

// File: rtl/tbc_checker.sv
module tbc_checker
  import tbc_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int CNT_W  = 56
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              busValid,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              rspValid,
  input logic              irq,
  input logic [CNT_W-1:0]  cntVal,
  input logic [CMP_W-1:0]  cmpVal,
  input logic              enQ,
  input logic              maskQ,
  input logic              statusQ
);
  localparam int PAD_W = CMP_W - CNT_W;

  logic ctrlWr;
  logic ackWr;
  logic matchNow;

  assign ctrlWr   = busValid && busWrite && ({{(32 - ADDR_W){1'b0}}, busAddr} == OFS_CTRL);
  assign ackWr    = ctrlWr && !busWdata[BIT_EN];
  assign matchNow = ({{PAD_W{1'b0}}, cntVal} >= cmpVal);

  // R2
  count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    tickEn |=> (cntVal == $past(cntVal) + CNT_W'(1)));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(cntVal));

  // R5
  match_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && !ackWr && matchNow) |=> statusQ);

  // R6
  above_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && (cmpVal[CMP_W-1:CNT_W] != '0)) |=> !statusQ);

  // R7
  sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !ackWr) |=> statusQ);

  // R8
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackWr |=> (!statusQ && !irq));

  // R9
  mask_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    maskQ |-> !irq);

  // R9
  irq_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (statusQ && enQ));

  // R11
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busWrite) |=> rspValid);

  // R11
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busValid && !busWrite) |=> !rspValid);
endmodule

bind time_base_cmp tbc_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .tickEn   (tickEn),
  .busValid (busValid),
  .busWrite (busWrite),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .rspValid (rspValid),
  .irq      (irq),
  .cntVal   (cntVal),
  .cmpVal   (cmpVal),
  .enQ      (enQ),
  .maskQ    (maskQ),
  .statusQ  (statusQ)
);

// File: tb/time_base_cmp_bench.sv
`timescale 1ns/1ps
module time_base_cmp_bench;
  localparam int ADDR_W = 17;
  localparam logic [31:0] A_CNT_LO = 32'h8;
  localparam logic [31:0] A_CNT_HI = 32'hC;
  localparam logic [31:0] A_CMP_LO = 32'h10020;
  localparam logic [31:0] A_CMP_HI = 32'h10024;
  localparam logic [31:0] A_CTRL   = 32'h1002C;
  localparam int N_VEC = 8;

  // {cmpHi[67:36], cmpLo[35:4], ctrl{mask,en}[3:2], expStatus[1], expIrq[0]}
  localparam logic [67:0] VEC [N_VEC] = '{
    {32'h0,         32'd50,  2'b01, 1'b1, 1'b1},  // R5 below
    {32'h0,         32'd100, 2'b01, 1'b1, 1'b1},  // R5 equal
    {32'h0,         32'd101, 2'b01, 1'b0, 1'b0},  // R5 above
    {32'h0,         32'd50,  2'b11, 1'b1, 1'b0},  // R9 masked
    {32'h0,         32'd50,  2'b00, 1'b0, 1'b0},  // R5 disabled
    {32'h1,         32'd0,   2'b01, 1'b0, 1'b0},  // R6 high word
    {32'h0100_0000, 32'd0,   2'b01, 1'b0, 1'b0},  // R6 bit 56
    {32'h0,         32'd0,   2'b01, 1'b1, 1'b1}   // R12 zero threshold
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              busValid = 1'b0;
  logic              busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic              busReady;
  logic              rspValid;
  logic [31:0]       rspData;
  logic              irq;

  int checks = 0;
  int errors = 0;
  logic [55:0] model;
  logic [31:0] rd;
  logic [31:0] rd2;
  logic [55:0] snap;
  logic [55:0] snap2;
  logic [31:0] baseCnt;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  // time base model from R2
  always @(posedge clk or negedge rstN) begin
    if (!rstN)       model <= '0;
    else if (tickEn) model <= model + 56'd1;
  end

  time_base_cmp #(.ADDR_W(ADDR_W), .CNT_W(56)) u_time_base_cmp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .rspValid(rspValid), .rspData(rspData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a[ADDR_W-1:0]; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic busRd(input logic [31:0] a, output logic [31:0] d, output logic [55:0] s);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a[ADDR_W-1:0];
    s = model;
    @(negedge clk);
    busValid = 1'b0;
    chk("R11 rspValid", {63'd0, rspValid}, 64'd1);
    d = rspData;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk("R1 irq", {63'd0, irq}, 64'd0);
    chk("R11 busReady", {63'd0, busReady}, 64'd1);
    busRd(A_CNT_LO, rd, snap); chk("R1 cnt lo", {32'd0, rd}, 64'd0);
    busRd(A_CMP_LO, rd, snap); chk("R1 cmp lo", {32'd0, rd}, 64'd0);
    busRd(A_CMP_HI, rd, snap); chk("R1 cmp hi", {32'd0, rd}, 64'd0);
    busRd(A_CTRL, rd, snap);   chk("R1 ctrl", {32'd0, rd}, 64'd0);

    // R2 counting and freezing
    ticks(100);
    busRd(A_CNT_LO, rd, snap); chk("R2 cnt lo", {32'd0, rd}, 64'd100);
    busRd(A_CNT_HI, rd, snap); chk("R2 cnt hi", {32'd0, rd}, 64'd0);
    busRd(A_CNT_LO, rd, snap); chk("R2 frozen", {32'd0, rd}, 64'd100);

    // vector table, time base frozen at 100
    for (int i = 0; i < N_VEC; i++) begin
      busWr(A_CTRL, 32'h0);
      busWr(A_CMP_LO, VEC[i][35:4]);
      busWr(A_CMP_HI, VEC[i][67:36]);
      busWr(A_CTRL, {30'd0, VEC[i][3:2]});
      chk("R9 irq vector", {63'd0, irq}, {63'd0, VEC[i][0]});
      busRd(A_CTRL, rd, snap);
      chk("R5 status vector", {63'd0, rd[2]}, {63'd0, VEC[i][1]});
      chk("R4 ctrl bits vector", {62'd0, rd[1:0]}, {62'd0, VEC[i][3:2]});
    end

    // R7 sticky after raising the threshold; R3 readback
    busWr(A_CMP_LO, 32'hFFFF_FFFF);
    busWr(A_CMP_HI, 32'h00FF_FFFF);
    busRd(A_CTRL, rd, snap);   chk("R7 status sticky", {32'd0, rd}, 64'h5);
    chk("R7 irq sticky", {63'd0, irq}, 64'd1);
    busRd(A_CMP_LO, rd, snap); chk("R3 cmp lo", {32'd0, rd}, 64'hFFFF_FFFF);
    busRd(A_CMP_HI, rd, snap); chk("R3 cmp hi", {32'd0, rd}, 64'h00FF_FFFF);

    // R8 acknowledge by clearing enable
    busWr(A_CTRL, 32'h0);
    chk("R8 irq after ack", {63'd0, irq}, 64'd0);
    busRd(A_CTRL, rd, snap); chk("R8 ctrl after ack", {32'd0, rd}, 64'd0);

    // R9 unmask with status pending
    busWr(A_CMP_LO, 32'd0);
    busWr(A_CMP_HI, 32'd0);
    busWr(A_CTRL, 32'h3);
    chk("R9 masked irq", {63'd0, irq}, 64'd0);
    busWr(A_CTRL, 32'h1);
    chk("R9 unmasked irq", {63'd0, irq}, 64'd1);

    // R4 status bit ignores writes
    busWr(A_CTRL, 32'h4);
    busRd(A_CTRL, rd, snap); chk("R4 status write ignored", {32'd0, rd}, 64'd0);
    busWr(A_CTRL, 32'hFFFF_FFFF);
    busRd(A_CTRL, rd, snap); chk("R4 ctrl all ones", {32'd0, rd}, 64'h7);

    // R10 unmapped offsets
    busWr(A_CTRL, 32'h0);
    busWr(A_CMP_LO, 32'h1234_5678);
    busWr(A_CMP_HI, 32'h0000_0009);
    busWr(32'h10028, 32'hFFFF_FFFF);
    busWr(32'h00010, 32'hFFFF_FFFF);
    busWr(32'h10000, 32'hFFFF_FFFF);
    busRd(32'h0, rd, snap);     chk("R10 read 0x0", {32'd0, rd}, 64'd0);
    busRd(32'h4, rd, snap);     chk("R10 read 0x4", {32'd0, rd}, 64'd0);
    busRd(32'h10028, rd, snap); chk("R10 read 0x10028", {32'd0, rd}, 64'd0);
    busRd(A_CMP_LO, rd, snap);  chk("R10 cmp lo kept", {32'd0, rd}, 64'h1234_5678);
    busRd(A_CMP_HI, rd, snap);  chk("R10 cmp hi kept", {32'd0, rd}, 64'h9);
    busRd(A_CTRL, rd, snap);    chk("R10 ctrl kept", {32'd0, rd}, 64'd0);
    busRd(A_CNT_LO, rd, snap);  chk("R10 cnt kept", {32'd0, rd}, 64'd100);

    // R5 exact match edge with a running time base
    baseCnt = model[31:0];
    busWr(A_CMP_LO, baseCnt + 32'd5);
    busWr(A_CMP_HI, 32'd0);
    busWr(A_CTRL, 32'h1);
    chk("R5 irq before run", {63'd0, irq}, 64'd0);
    ticks(5);
    chk("R5 irq at reach edge", {63'd0, irq}, 64'd0);
    @(negedge clk);
    chk("R5 irq one edge later", {63'd0, irq}, 64'd1);

    // R2 high/low/high reads while running
    @(negedge clk);
    tickEn = 1'b1;
    busRd(A_CNT_HI, rd, snap);
    busRd(A_CNT_LO, rd2, snap2);
    chk("R2 running lo", {32'd0, rd2}, {32'd0, snap2[31:0]});
    busRd(A_CNT_HI, rd2, snap);
    chk("R2 hi consistent", {32'd0, rd2}, {32'd0, rd});
    tickEn = 1'b0;

    // R1 reset in mid-run with status set
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    chk("R1 irq in reset", {63'd0, irq}, 64'd0);
    rstN = 1'b1;
    busRd(A_CTRL, rd, snap);   chk("R1 ctrl after reset", {32'd0, rd}, 64'd0);
    busRd(A_CNT_LO, rd, snap); chk("R1 cnt after reset", {32'd0, rd}, 64'd0);
    busRd(A_CMP_LO, rd, snap); chk("R1 cmp after reset", {32'd0, rd}, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule